// File: doc/BRIEF.md
# Reference-Rate Time Stamp Counter with Deadline Interrupt

This block keeps a 64-bit count that advances by one on every cycle in which a fixed-rate reference tick is high. The core clock only samples that tick. Frequency-scaling and low-power inputs reach the block, but they have no effect on the count, so the value tracks elapsed time and not work done by the core. Software sees an adjusted time: the raw count plus a programmable offset register. This lets a platform shift the visible time without rewriting the running count.

A read strobe captures the adjusted time. One cycle later the block presents it as an upper 32-bit word and a lower 32-bit word, with a valid pulse. A second request bit asks for this instance's core identifier to come back alongside the value, so software can tell which counter produced a sample. A deadline register arms a comparator. When the adjusted time reaches the programmed deadline on a tick, a level interrupt is raised. It stays high until software writes a new deadline.

Top module: `tsc_deadline_timer`

## Requirements
- R1: After a synchronous active-low reset, the raw count, the offset and the deadline are all zero. `irq_o` and `rd_valid_o` are low, and a read returns zero.
- R2: On a clock edge where `ref_tick_i` is high and no count write is present, the raw count increases by exactly one. Without a tick it holds. It wraps modulo 2^64.
- R3: `sleep_i` and `scale_i` have no effect: with either of them active, N ticks still advance the adjusted time by exactly N.
- R4: A read strobe `rd_en_i` captures raw count plus offset (modulo 2^64). On the next cycle the block shows bits 63:32 on `rd_hi_o` and bits 31:0 on `rd_lo_o`, and `rd_valid_o` is high for that one cycle.
- R5: When `rd_id_i` is high with the read strobe, `rd_core_id_o` carries the `CORE_ID` parameter in the result cycle. Otherwise it is zero.
- R6: Writes use `wr_en_i` with `wr_sel_i`: 2'b00 loads the raw count, 2'b01 the offset, 2'b10 the deadline, and 2'b11 writes nothing. A count load takes priority over a tick in the same cycle.
- R7: On a tick edge with no write, if the adjusted time after the increment is greater than or equal to a non-zero deadline, `irq_o` rises at that edge. It then stays high.
- R8: A deadline of zero disarms the comparator, so `irq_o` stays low however large the adjusted time is.
- R9: Any deadline write clears `irq_o` at that edge. The interrupt fires at most once per written deadline.
- R10: A deadline that is already behind the adjusted time does not fire on idle cycles. It fires on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick_i | input | 1 | Fixed-rate reference tick, one count per high cycle |
| sleep_i | input | 1 | Low-power indication, does not stop counting |
| scale_i | input | 2 | Core clock scaling level, does not affect counting |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 00 count, 01 offset, 10 deadline, 11 none |
| wr_data_i | input | 64 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_id_i | input | 1 | Ask for the core identifier with this read |
| rd_hi_o | output | 32 | Upper half of the adjusted time |
| rd_lo_o | output | 32 | Lower half of the adjusted time |
| rd_core_id_o | output | 8 | Core identifier, or zero |
| rd_valid_o | output | 1 | Read result valid, one cycle |
| irq_o | output | 1 | Deadline interrupt, level |

## Verification
The assertions assume that `ref_tick_i` and every strobe are synchronous to `clk` and stable across the sampling edge. They also assume that the tick is a plain enable, not an edge to be detected. The bench changes all inputs on the falling edge and holds each strobe for whole cycles. It keeps 64-bit wrap of the adjusted time out of the deadline tests, because the comparison is unsigned. It does use wrap in the read checks, where the modular sum is what matters.

// File: rtl/tsc_pkg.sv
// Shared definitions for the time stamp counter.
// Assumes a two-bit write selector from the register interface.
package tsc_pkg;
    typedef enum logic [1:0] {
        WR_COUNT    = 2'b00,
        WR_OFFSET   = 2'b01,
        WR_DEADLINE = 2'b10,
        WR_NONE     = 2'b11
    } wr_tgt_e;
endpackage

// File: rtl/tsc_count_core.sv
// Raw reference-rate counter plus offset register.
// Produces the adjusted time now and the adjusted time one tick later.
// Assumes tick_i is a single-cycle-per-count enable in the clk domain.
module tsc_count_core #(
    parameter int CNT_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 wr_en_i,
    input  tsc_pkg::wr_tgt_e     wr_tgt_i,
    input  logic [CNT_W-1:0]     wr_data_i,
    output logic [CNT_W-1:0]     adj_o,
    output logic [CNT_W-1:0]     adj_next_o
);
    import tsc_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] off_q;
    logic             load_cnt;
    logic             load_off;

    assign load_cnt = wr_en_i && (wr_tgt_i == WR_COUNT);
    assign load_off = wr_en_i && (wr_tgt_i == WR_OFFSET);

    // Raw count: load wins over tick, otherwise advance on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (load_cnt) cnt_q <= wr_data_i;
        else if (tick_i)   cnt_q <= cnt_q + ONE;
    end

    // Offset register written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        off_q <= '0;
        else if (load_off) off_q <= wr_data_i;
    end

    // Adjusted time now and after one more tick.
    always_comb begin
        adj_o      = cnt_q + off_q;
        adj_next_o = cnt_q + ONE + off_q;
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_cnt) |=> (cnt_q == $past(cnt_q) + ONE));
    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_cnt) |=> $stable(cnt_q));
    // R6
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_cnt |=> (cnt_q == $past(wr_data_i)));
    // R6
    off_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_off |=> (off_q == $past(wr_data_i)));
endmodule

// File: rtl/tsc_deadline_cmp.sv
// Deadline register and one-shot interrupt latch.
// The compare runs only on tick cycles with no register write.
// Assumes adj_next_i is the adjusted time after the current tick.
module tsc_deadline_cmp #(
    parameter int CNT_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 wr_en_i,
    input  tsc_pkg::wr_tgt_e     wr_tgt_i,
    input  logic [CNT_W-1:0]     wr_data_i,
    input  logic [CNT_W-1:0]     adj_next_i,
    output logic                 irq_o
);
    import tsc_pkg::*;

    logic [CNT_W-1:0] dl_q;
    logic             irq_q;
    logic             load_dl;
    logic             armed;
    logic             hit;

    assign load_dl = wr_en_i && (wr_tgt_i == WR_DEADLINE);
    assign armed   = (dl_q != '0);
    assign hit     = tick_i && !wr_en_i && armed && (adj_next_i >= dl_q);

    // Deadline register written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       dl_q <= '0;
        else if (load_dl) dl_q <= wr_data_i;
    end

    // Interrupt latch: set on hit, cleared by any deadline write.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (load_dl) irq_q <= 1'b0;
        else if (hit)     irq_q <= 1'b1;
    end

    assign irq_o = irq_q;

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_dl |=> !irq_o);
    // R8
    irq_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_q == '0) |-> !irq_o);
    // R10
    irq_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(tick_i));
    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !load_dl) |=> irq_o);
endmodule

// File: rtl/tsc_read_port.sv
// Read capture: registers the adjusted time split in two halves,
// a one-cycle valid and the optional core identifier.
// Assumes CNT_W is twice HALF_W.
module tsc_read_port #(
    parameter int              CNT_W   = 64,
    parameter int              ID_W    = 8,
    parameter logic [ID_W-1:0] CORE_ID = 8'h05
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en_i,
    input  logic                   rd_id_i,
    input  logic [CNT_W-1:0]       adj_i,
    output logic [CNT_W/2-1:0]     hi_o,
    output logic [CNT_W/2-1:0]     lo_o,
    output logic [ID_W-1:0]        id_o,
    output logic                   valid_o
);
    localparam int HALF_W = CNT_W / 2;

    logic [HALF_W-1:0] half_q [2];
    logic              valid_q;
    logic              id_q;

    // One capture register per half.
    for (genvar g = 0; g < 2; g++) begin : g_half
        always_ff @(posedge clk) begin
            if (!rst_n)       half_q[g] <= '0;
            else if (rd_en_i) half_q[g] <= adj_i[g*HALF_W +: HALF_W];
        end
    end

    // Valid pulse and identifier request follow the strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            id_q    <= 1'b0;
        end else begin
            valid_q <= rd_en_i;
            id_q    <= rd_en_i && rd_id_i;
        end
    end

    assign lo_o    = half_q[0];
    assign hi_o    = half_q[1];
    assign valid_o = valid_q;
    assign id_o    = id_q ? CORE_ID : '0;

    // R4
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> valid_o);
    // R4
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> ({hi_o, lo_o} == $past(adj_i)));
    // R5
    rd_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !rd_id_i) |=> (id_o == '0));
endmodule

// File: rtl/tsc_deadline_timer.sv
// Top of the time stamp counter: reference-rate count, offset,
// deadline interrupt and split read port with core identifier.
// Assumes all inputs are synchronous to clk.
module tsc_deadline_timer #(
    parameter int              CNT_W   = 64,
    parameter int              ID_W    = 8,
    parameter logic [ID_W-1:0] CORE_ID = 8'h05
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_tick_i,
    input  logic                 sleep_i,
    input  logic [1:0]           scale_i,
    input  logic                 wr_en_i,
    input  logic [1:0]           wr_sel_i,
    input  logic [CNT_W-1:0]     wr_data_i,
    input  logic                 rd_en_i,
    input  logic                 rd_id_i,
    output logic [CNT_W/2-1:0]   rd_hi_o,
    output logic [CNT_W/2-1:0]   rd_lo_o,
    output logic [ID_W-1:0]      rd_core_id_o,
    output logic                 rd_valid_o,
    output logic                 irq_o
);
    import tsc_pkg::*;

    wr_tgt_e          wr_tgt;
    logic [CNT_W-1:0] adj_w;
    logic [CNT_W-1:0] adj_next_w;

    assign wr_tgt = wr_tgt_e'(wr_sel_i);

    tsc_count_core #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (ref_tick_i),
        .wr_en_i    (wr_en_i),
        .wr_tgt_i   (wr_tgt),
        .wr_data_i  (wr_data_i),
        .adj_o      (adj_w),
        .adj_next_o (adj_next_w)
    );

    tsc_deadline_cmp #(.CNT_W(CNT_W)) u_deadline (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (ref_tick_i),
        .wr_en_i    (wr_en_i),
        .wr_tgt_i   (wr_tgt),
        .wr_data_i  (wr_data_i),
        .adj_next_i (adj_next_w),
        .irq_o      (irq_o)
    );

    tsc_read_port #(.CNT_W(CNT_W), .ID_W(ID_W), .CORE_ID(CORE_ID)) u_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en_i (rd_en_i),
        .rd_id_i (rd_id_i),
        .adj_i   (adj_w),
        .hi_o    (rd_hi_o),
        .lo_o    (rd_lo_o),
        .id_o    (rd_core_id_o),
        .valid_o (rd_valid_o)
    );

    // R3
    lowpower_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tick_i && !wr_en_i && (sleep_i || (scale_i != 2'b00)))
        |=> (adj_w == $past(adj_w) + CNT_W'(1)));
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (adj_w == '0 && !irq_o && !rd_valid_o));
endmodule

// File: tb/tsc_deadline_timer_tb_top.sv
module tsc_deadline_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        sleep = 1'b0;
    logic [1:0]  scale = 2'b00;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'b11;
    logic [63:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        rd_id = 1'b0;
    logic [31:0] rd_hi;
    logic [31:0] rd_lo;
    logic [7:0]  rd_core_id;
    logic        rd_valid;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [7:0] ID_VAL = 8'h05;

    always #2 clk = ~clk;

    tsc_deadline_timer dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick), .sleep_i(sleep),
        .scale_i(scale), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_id_i(rd_id),
        .rd_hi_o(rd_hi), .rd_lo_o(rd_lo), .rd_core_id_o(rd_core_id),
        .rd_valid_o(rd_valid), .irq_o(irq)
    );

    // Vector: count load, offset, ticks, expected adjusted read.
    typedef struct packed {
        logic [63:0] load;
        logic [63:0] off;
        logic [7:0]  ticks;
        logic [63:0] exp;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{64'd0, 64'd0, 8'd3, 64'd3},
        '{64'd100, 64'd20, 8'd5, 64'd125},
        '{64'h0000_0000_FFFF_FFFE, 64'd0, 8'd3, 64'h0000_0001_0000_0001},
        '{64'd10, 64'hFFFF_FFFF_FFFF_FFFF, 8'd2, 64'd11},
        '{64'h1234_5678_9ABC_DEF0, 64'h10, 8'd0, 64'h1234_5678_9ABC_DF00}
    };

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [63:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_sel = 2'b11;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1'b1;
        end
        @(negedge clk); ref_tick = 1'b0;
    endtask

    task automatic rd(input logic idf, output logic [63:0] v,
                      output logic [7:0] id, output logic vl);
        @(negedge clk); rd_en = 1'b1; rd_id = idf;
        @(negedge clk); rd_en = 1'b0; rd_id = 1'b0;
        v = {rd_hi, rd_lo}; id = rd_core_id; vl = rd_valid;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        logic [63:0] v, a;
        logic [7:0]  id;
        logic        vl;

        do_reset();
        // R1 reset state
        check(irq == 1'b0, "R1 irq", 64'(irq), 0);
        check(rd_valid == 1'b0, "R1 valid", 64'(rd_valid), 0);
        rd(1'b0, v, id, vl);
        check(v == 0, "R1 read", v, 0);

        // Table walk: R2 R4 R5 R6 with wrap cases
        for (int k = 0; k < 5; k++) begin
            wr(2'b00, VECS[k].load);
            wr(2'b01, VECS[k].off);
            if (VECS[k].ticks != 0) tick(int'(VECS[k].ticks));
            rd(k[0], v, id, vl);
            check(v == VECS[k].exp, "R2/R4 table value", v, VECS[k].exp);
            check(vl == 1'b1, "R4 valid", 64'(vl), 1);
            check(id == (k[0] ? ID_VAL : 8'h00), "R5 core id", 64'(id),
                  64'(k[0] ? ID_VAL : 8'h00));
        end
        @(negedge clk);
        check(rd_valid == 1'b0, "R4 valid one cycle", 64'(rd_valid), 0);

        // R6 count load beats tick; 2'b11 writes nothing
        wr(2'b01, 64'd0);
        @(negedge clk); wr_en = 1'b1; wr_sel = 2'b00; wr_data = 64'd500; ref_tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; wr_sel = 2'b11; ref_tick = 1'b0;
        wr(2'b11, 64'd9999);
        rd(1'b0, v, id, vl);
        check(v == 64'd500, "R6 load priority / no-op select", v, 500);

        // Reset clears offset and count
        wr(2'b01, 64'd77);
        do_reset();
        rd(1'b0, v, id, vl);
        check(v == 0, "R1 reset clears offset", v, 0);

        // R8 disarmed with deadline zero
        tick(3);
        check(irq == 1'b0, "R8 zero deadline", 64'(irq), 0);

        // R7 fires exactly when adjusted time reaches deadline
        wr(2'b10, 64'd10);
        tick(6);
        check(irq == 1'b0, "R7 before deadline", 64'(irq), 0);
        tick(1);
        check(irq == 1'b1, "R7 at deadline", 64'(irq), 1);
        tick(2);
        check(irq == 1'b1, "R7 stays high", 64'(irq), 1);

        // R9 clear by write, R8 disarm
        wr(2'b10, 64'd0);
        check(irq == 1'b0, "R9 clear on write", 64'(irq), 0);
        tick(2);
        check(irq == 1'b0, "R8 stays low", 64'(irq), 0);

        // R10 past deadline waits for a tick
        wr(2'b10, 64'd5);
        check(irq == 1'b0, "R9 clear past write", 64'(irq), 0);
        repeat (3) @(negedge clk);
        check(irq == 1'b0, "R10 no fire without tick", 64'(irq), 0);
        tick(1);
        check(irq == 1'b1, "R10 fires on next tick", 64'(irq), 1);

        // R7 offset is part of the compare (adjusted 115 here)
        wr(2'b01, 64'd100);
        wr(2'b10, 64'd120);
        check(irq == 1'b0, "R9 clear new deadline", 64'(irq), 0);
        tick(4);
        check(irq == 1'b0, "R7 offset before", 64'(irq), 0);
        tick(1);
        check(irq == 1'b1, "R7 offset at deadline", 64'(irq), 1);

        // R3 sleep and scaling do not change counting
        sleep = 1'b1; scale = 2'b11;
        rd(1'b0, a, id, vl);
        tick(7);
        rd(1'b1, v, id, vl);
        check(v == a + 64'd7, "R3 low power counting", v, a + 64'd7);
        repeat (4) @(negedge clk);
        rd(1'b0, v, id, vl);
        check(v == a + 64'd7, "R2 hold without tick", v, a + 64'd7);
        sleep = 1'b0; scale = 2'b00;

        finish_run();
    end
endmodule